// File: doc/BRIEF.md
# Burst Limit Encoder with Bucket Units

This block turns a requested burst size in bytes into the compact form a token-bucket policer stores: a limit mantissa and exponent, plus an initial bucket fill value. It receives the burst together with the rate that has already been encoded. That rate arrives as a mantissa and an exponent, and its value in bytes per tick is the mantissa shifted left by the exponent. The rate sets two things: the default burst used when none is requested, and the unit in which the bucket field counts. The unit is 1, 2, 4 or 8 bytes.

A request is raised with a single-cycle `start`. The block first chooses the working burst. A request of zero means 100 ticks' worth of traffic. The result is then held below the largest value that both the bucket field and the limit encoding can represent, and after that raised to a floor of 9216 bytes. The working burst is encoded with round-down. The search walks upward one exponent per cycle and stops at the first exponent where the mantissa fits. A skip input serves the excess bucket of a single-rate two-color policer, which keeps an empty limit. Field widths are parameters, so one instance can serve the committed bucket and another the excess bucket.

The control is a five-state machine. IDLE waits for `start`, latches the inputs and moves to PREP. PREP goes to DONE when skip is set and to SEARCH otherwise. SEARCH stays while the mantissa does not fit, incrementing the exponent, and goes to FILL when it fits or the exponent is at its maximum. FILL goes to DONE. DONE returns to IDLE.

Top module: `burst_limit_encoder`

## Requirements
- R1: After reset `busy`, `done`, `lim_mant`, `lim_exp` and `bkt_fill` are all zero.
- R2: A `start` seen while `busy` is low is accepted, and `busy` is high in the next cycle. A `start` while `busy` is high is ignored. `done` is high for exactly one cycle. The three result outputs change only in the cycle in which `done` is high and hold otherwise.
- R3: A requested burst of zero is replaced by 100 times the rate in bytes per tick, where the rate is `rate_mant` shifted left by `rate_exp`.
- R4: The bucket unit is 1 byte for a rate of at most 64 bytes per tick, 2 bytes for at most 128, 4 bytes for at most 256, and 8 bytes above that.
- R5: The working burst is limited to the smaller of unit×(2^BKT_W−1) and (2^MANT_W−1) shifted left by (2^EXP_W−1).
- R6: After the upper limit is applied, a working burst below 9216 bytes is raised to 9216.
- R7: `lim_exp` is the smallest exponent at which the working burst shifted right by it is at most 2^MANT_W−1. `lim_mant` is that shifted value, rounded down.
- R8: `bkt_fill` equals (`lim_mant` shifted left by `lim_exp`) divided by the bucket unit.
- R9: With `skip_excess` high at acceptance, the result is `lim_mant`=0, `lim_exp`=2^EXP_W−1 and `bkt_fill`=0, whatever the burst and rate are.
- R10: Counting the accepting clock edge as edge 0, `done` is first high after edge 3+`lim_exp` for an encoded request and after edge 1 for a skipped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted when idle |
| skip_excess | input | 1 | Produce the empty excess-bucket limit |
| burst_bytes | input | BURST_W | Requested burst in bytes, 0 selects the default |
| rate_mant | input | RM_W | Encoded rate mantissa |
| rate_exp | input | RE_W | Encoded rate exponent |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| lim_mant | output | MANT_W | Burst limit mantissa |
| lim_exp | output | EXP_W | Burst limit exponent |
| bkt_fill | output | BKT_W | Initial bucket value in rate-dependent units |

## Verification
Two pairs of functions can act on the same request. A zero burst at a low rate triggers the default substitution and the 9216-byte floor together, so the output shows whether the floor is applied after the default. An oversized burst at a rate above 64 bytes per tick hits the upper limit and the unit scaling together, so the fill shows whether the limit is scaled by the unit before the division. Both cases are driven as single requests and judged against the encoding computed from the requirements, together with the latency tied to the final exponent.

// File: rtl/blenc_pkg.sv
package blenc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SEARCH,
        ST_FILL,
        ST_DONE
    } blenc_state_e;

    // log2 of the bucket unit in bytes (0..3 -> 1,2,4,8)
    typedef logic [1:0] unit_shift_t;

endpackage

// File: rtl/blenc_tier.sv
module blenc_tier
    import blenc_pkg::*;
#(
    parameter int CALC_W = 48,
    parameter int TIER1  = 64,
    parameter int TIER2  = 128,
    parameter int TIER3  = 256
) (
    input  logic [CALC_W-1:0] rate_bpt,
    output unit_shift_t       unit_sh
);

    localparam logic [CALC_W-1:0] LIM1 = CALC_W'(TIER1);
    localparam logic [CALC_W-1:0] LIM2 = CALC_W'(TIER2);
    localparam logic [CALC_W-1:0] LIM3 = CALC_W'(TIER3);

    always_comb begin
        if (rate_bpt <= LIM1) begin
            unit_sh = 2'd0;
        end else if (rate_bpt <= LIM2) begin
            unit_sh = 2'd1;
        end else if (rate_bpt <= LIM3) begin
            unit_sh = 2'd2;
        end else begin
            unit_sh = 2'd3;
        end
    end

endmodule

// File: rtl/blenc_clamp.sv
module blenc_clamp
    import blenc_pkg::*;
#(
    parameter int CALC_W    = 48,
    parameter int BURST_W   = 32,
    parameter int BKT_W     = 31,
    parameter int MANT_W    = 7,
    parameter int EXP_W     = 5,
    parameter int MIN_BURST = 9216,
    parameter int DEF_MULT  = 100
) (
    input  logic [BURST_W-1:0] burst,
    input  logic [CALC_W-1:0]  rate_bpt,
    input  unit_shift_t        unit_sh,
    output logic [CALC_W-1:0]  clamped
);

    localparam int               EXP_MAX   = (1 << EXP_W) - 1;
    localparam logic [CALC_W-1:0] MANT_MAXW = CALC_W'((1 << MANT_W) - 1);
    localparam logic [CALC_W-1:0] MANT_CAP  = MANT_MAXW << EXP_MAX;
    localparam logic [CALC_W-1:0] FIELD_MAX = (CALC_W'(1) << BKT_W) - CALC_W'(1);
    localparam logic [CALC_W-1:0] FLOOR_W   = CALC_W'(MIN_BURST);
    localparam logic [CALC_W-1:0] MULT_W    = CALC_W'(DEF_MULT);

    logic [CALC_W-1:0] wanted;
    logic [CALC_W-1:0] field_cap;
    logic [CALC_W-1:0] upper;
    logic [CALC_W-1:0] below_top;

    always_comb begin
        // zero request: a fixed number of ticks at the encoded rate
        if (burst == '0) begin
            wanted = rate_bpt * MULT_W;
        end else begin
            wanted = CALC_W'(burst);
        end
        field_cap = FIELD_MAX << unit_sh;
        upper     = (field_cap < MANT_CAP) ? field_cap : MANT_CAP;
        below_top = (wanted > upper) ? upper : wanted;
        // floor is applied after the ceiling
        clamped   = (below_top < FLOOR_W) ? FLOOR_W : below_top;
    end

endmodule

// File: rtl/blenc_step.sv
module blenc_step #(
    parameter int CALC_W = 48,
    parameter int MANT_W = 7,
    parameter int EXP_W  = 5
) (
    input  logic [CALC_W-1:0] value,
    input  logic [EXP_W-1:0]  exp_idx,
    output logic [MANT_W-1:0] mant_try,
    output logic              fits
);

    localparam logic [CALC_W-1:0] MANT_MAXW = CALC_W'((1 << MANT_W) - 1);

    logic [CALC_W-1:0] shifted;

    always_comb begin
        shifted  = value >> exp_idx;
        fits     = (shifted <= MANT_MAXW);
        mant_try = shifted[MANT_W-1:0];
    end

endmodule

// File: rtl/burst_limit_encoder.sv
module burst_limit_encoder
    import blenc_pkg::*;
#(
    parameter int BURST_W   = 32,
    parameter int RM_W      = 11,
    parameter int RE_W      = 4,
    parameter int MANT_W    = 7,
    parameter int EXP_W     = 5,
    parameter int BKT_W     = 31,
    parameter int CALC_W    = 48,
    parameter int MIN_BURST = 9216,
    parameter int DEF_MULT  = 100,
    parameter int TIER1     = 64,
    parameter int TIER2     = 128,
    parameter int TIER3     = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               skip_excess,
    input  logic [BURST_W-1:0] burst_bytes,
    input  logic [RM_W-1:0]    rate_mant,
    input  logic [RE_W-1:0]    rate_exp,
    output logic               busy,
    output logic               done,
    output logic [MANT_W-1:0]  lim_mant,
    output logic [EXP_W-1:0]   lim_exp,
    output logic [BKT_W-1:0]   bkt_fill
);

    localparam logic [MANT_W-1:0] MANT_TOP = '1;
    localparam logic [EXP_W-1:0]  EXP_TOP  = '1;

    blenc_state_e st, st_nx;

    // latched request
    logic [BURST_W-1:0] r_burst;
    logic [RM_W-1:0]    r_rmant;
    logic [RE_W-1:0]    r_rexp;
    logic               r_skip;

    // working registers
    logic [CALC_W-1:0]  r_val;
    logic [EXP_W-1:0]   r_exp;
    logic [MANT_W-1:0]  r_mant;
    unit_shift_t        r_unit;

    // combinational helpers
    logic [CALC_W-1:0]  rate_bpt;
    unit_shift_t        unit_sh;
    logic [CALC_W-1:0]  clamped;
    logic [MANT_W-1:0]  mant_try;
    logic               fits;
    logic [CALC_W-1:0]  fill_full;

    assign rate_bpt  = CALC_W'(r_rmant) << r_rexp;
    assign fill_full = (CALC_W'(r_mant) << r_exp) >> r_unit;

    blenc_tier #(
        .CALC_W (CALC_W),
        .TIER1  (TIER1),
        .TIER2  (TIER2),
        .TIER3  (TIER3)
    ) u_tier (
        .rate_bpt (rate_bpt),
        .unit_sh  (unit_sh)
    );

    blenc_clamp #(
        .CALC_W    (CALC_W),
        .BURST_W   (BURST_W),
        .BKT_W     (BKT_W),
        .MANT_W    (MANT_W),
        .EXP_W     (EXP_W),
        .MIN_BURST (MIN_BURST),
        .DEF_MULT  (DEF_MULT)
    ) u_clamp (
        .burst    (r_burst),
        .rate_bpt (rate_bpt),
        .unit_sh  (unit_sh),
        .clamped  (clamped)
    );

    blenc_step #(
        .CALC_W (CALC_W),
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_step (
        .value    (r_val),
        .exp_idx  (r_exp),
        .mant_try (mant_try),
        .fits     (fits)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = ST_PREP;
            ST_PREP:   st_nx = r_skip ? ST_DONE : ST_SEARCH;
            ST_SEARCH: if (fits || (r_exp == EXP_TOP)) st_nx = ST_FILL;
            ST_FILL:   st_nx = ST_DONE;
            ST_DONE:   st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_burst  <= '0;
            r_rmant  <= '0;
            r_rexp   <= '0;
            r_skip   <= 1'b0;
            r_val    <= '0;
            r_exp    <= '0;
            r_mant   <= '0;
            r_unit   <= '0;
            lim_mant <= '0;
            lim_exp  <= '0;
            bkt_fill <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        r_burst <= burst_bytes;
                        r_rmant <= rate_mant;
                        r_rexp  <= rate_exp;
                        r_skip  <= skip_excess;
                    end
                end
                ST_PREP: begin
                    if (r_skip) begin
                        lim_mant <= '0;
                        lim_exp  <= EXP_TOP;
                        bkt_fill <= '0;
                    end else begin
                        r_val  <= clamped;
                        r_exp  <= '0;
                        r_unit <= unit_sh;
                    end
                end
                ST_SEARCH: begin
                    if (fits) begin
                        r_mant <= mant_try;
                    end else if (r_exp == EXP_TOP) begin
                        r_mant <= MANT_TOP;
                    end else begin
                        r_exp <= r_exp + EXP_W'(1);
                    end
                end
                ST_FILL: begin
                    lim_mant <= r_mant;
                    lim_exp  <= r_exp;
                    bkt_fill <= fill_full[BKT_W-1:0];
                end
                default: begin
                end
            endcase
        end
    end

    // status outputs
    always_comb begin
        busy = (st != ST_IDLE);
        done = (st == ST_DONE);
    end

endmodule

// File: rtl/blenc_checker.sv
module blenc_checker #(
    parameter int MANT_W = 7,
    parameter int EXP_W  = 5,
    parameter int BKT_W  = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [MANT_W-1:0] lim_mant,
    input logic [EXP_W-1:0]  lim_exp,
    input logic [BKT_W-1:0]  bkt_fill,
    input logic              skip_q
);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("accepted start did not raise busy");

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lim_mant) || !$stable(lim_exp) || !$stable(bkt_fill)) |-> done)
        else $error("result changed outside done");

    // a nonzero exponent is only chosen when the mantissa uses its top bit
    assert_lowest_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !skip_q && (lim_exp != '0)) |-> lim_mant[MANT_W-1])
        else $error("exponent not the smallest that fits");

    assert_skip_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skip_q) |-> ((lim_mant == '0) && (lim_exp == '1) && (bkt_fill == '0)))
        else $error("skip result wrong");

endmodule

bind burst_limit_encoder blenc_checker #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W),
    .BKT_W  (BKT_W)
) u_blenc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .lim_mant (lim_mant),
    .lim_exp  (lim_exp),
    .bkt_fill (bkt_fill),
    .skip_q   (r_skip)
);

// File: tb/burst_limit_encoder_bench.sv
module burst_limit_encoder_bench;

    localparam int MW  = 7;
    localparam int EW  = 5;
    localparam int SEW = 3;
    localparam int BW  = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // main instance
    logic        m_start = 1'b0;
    logic        m_skip = 1'b0;
    logic [31:0] m_burst = '0;
    logic [10:0] m_rmant = '0;
    logic [3:0]  m_rexp = '0;
    logic        m_busy, m_done;
    logic [MW-1:0] m_mant;
    logic [EW-1:0] m_exp;
    logic [BW-1:0] m_fill;

    // instance with a narrow exponent field
    logic        s_start = 1'b0;
    logic [31:0] s_burst = '0;
    logic [10:0] s_rmant = '0;
    logic        s_busy, s_done;
    logic [MW-1:0]  s_mant;
    logic [SEW-1:0] s_exp;
    logic [BW-1:0]  s_fill;

    burst_limit_encoder #(.MANT_W(MW), .EXP_W(EW), .BKT_W(BW)) u_burst_limit_encoder (
        .clk(clk), .rst_n(rst_n), .start(m_start), .skip_excess(m_skip),
        .burst_bytes(m_burst), .rate_mant(m_rmant), .rate_exp(m_rexp),
        .busy(m_busy), .done(m_done), .lim_mant(m_mant), .lim_exp(m_exp),
        .bkt_fill(m_fill)
    );

    burst_limit_encoder #(.MANT_W(MW), .EXP_W(SEW), .BKT_W(BW)) u_small (
        .clk(clk), .rst_n(rst_n), .start(s_start), .skip_excess(1'b0),
        .burst_bytes(s_burst), .rate_mant(s_rmant), .rate_exp(4'd0),
        .busy(s_busy), .done(s_done), .lim_mant(s_mant), .lim_exp(s_exp),
        .bkt_fill(s_fill)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected encoding from the requirements
    function automatic void model(input longint unsigned burst, input int rm, input int re,
                                  input bit skip, input int ew,
                                  output longint unsigned em, output longint unsigned ee,
                                  output longint unsigned ef, output int lat);
        longint unsigned rate, b, capb, capm, cap, maxm;
        int ush, maxe;
        rate = longint'(rm) << re;
        ush  = (rate <= 64) ? 0 : (rate <= 128) ? 1 : (rate <= 256) ? 2 : 3;
        maxm = (64'd1 << MW) - 1;
        maxe = (1 << ew) - 1;
        if (skip) begin
            em = 0; ee = maxe; ef = 0; lat = 1;
            return;
        end
        b    = (burst == 0) ? rate * 100 : burst;
        capb = ((64'd1 << BW) - 1) << ush;
        capm = maxm << maxe;
        cap  = (capb < capm) ? capb : capm;
        if (b > cap) b = cap;
        if (b < 9216) b = 9216;
        ee = maxe;
        em = maxm;
        for (int e = maxe; e >= 0; e--) begin
            if ((b >> e) <= maxm) begin
                ee = e;
                em = b >> e;
            end
        end
        ef  = (em << ee) >> ush;
        lat = 3 + int'(ee);
    endfunction

    task automatic wait_main_done(output int n);
        n = 0;
        while (!m_done && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic encode(input string req, input longint unsigned burst,
                          input int rm, input int re, input bit skip);
        longint unsigned em, ee, ef;
        int el, n;
        model(burst, rm, re, skip, EW, em, ee, ef, el);
        @(negedge clk);
        m_start = 1'b1; m_burst = burst[31:0]; m_rmant = rm[10:0];
        m_rexp = re[3:0]; m_skip = skip;
        @(posedge clk);
        @(negedge clk);
        m_start = 1'b0;
        chk(req, "busy after accept", m_busy, 1);
        wait_main_done(n);
        chk("R10", {req, " latency"}, n, el);
        chk(req, "lim_mant", m_mant, em);
        chk(req, "lim_exp", m_exp, ee);
        chk(req, "bkt_fill", m_fill, ef);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy", m_busy, 0);
        chk("R1", "done", m_done, 0);
        chk("R1", "lim_mant", m_mant, 0);
        chk("R1", "lim_exp", m_exp, 0);
        chk("R1", "bkt_fill", m_fill, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_plain;
        encode("R7", 20000, 10, 0, 1'b0);
        chk("R7", "20000 B mantissa", m_mant, 78);
        chk("R7", "20000 B exponent", m_exp, 8);
        chk("R8", "20000 B fill unit 1", m_fill, 19968);
    endtask

    task automatic t_default;
        // rate 25<<3 = 200 B/tick, unit 4, default 20000 B
        encode("R3", 0, 25, 3, 1'b0);
        chk("R3", "default mantissa", m_mant, 78);
        chk("R3", "default exponent", m_exp, 8);
        chk("R3", "default fill unit 4", m_fill, 4992);
    endtask

    task automatic t_floor;
        encode("R6", 100, 10, 0, 1'b0);
        chk("R6", "floor mantissa", m_mant, 72);
        chk("R6", "floor exponent", m_exp, 7);
        chk("R6", "floor fill", m_fill, 9216);
        // default of 5000 B then floor
        encode("R6", 0, 50, 0, 1'b0);
        chk("R6", "default then floor fill", m_fill, 9216);
        chk("R3", "default then floor exponent", m_exp, 7);
    endtask

    task automatic t_tiers;
        encode("R4", 20000, 64, 0, 1'b0);
        chk("R4", "rate 64 fill", m_fill, 19968);
        encode("R4", 20000, 65, 0, 1'b0);
        chk("R4", "rate 65 fill", m_fill, 9984);
        encode("R4", 20000, 128, 0, 1'b0);
        chk("R4", "rate 128 fill", m_fill, 9984);
        encode("R4", 20000, 129, 0, 1'b0);
        chk("R4", "rate 129 fill", m_fill, 4992);
        encode("R4", 20000, 256, 0, 1'b0);
        chk("R4", "rate 256 fill", m_fill, 4992);
        encode("R4", 20000, 257, 0, 1'b0);
        chk("R4", "rate 257 fill", m_fill, 2496);
    endtask

    task automatic t_upper_field;
        encode("R5", 64'hFFFF_FFFF, 10, 0, 1'b0);
        chk("R5", "field cap unit 1 exponent", m_exp, 24);
        chk("R5", "field cap unit 1 fill", m_fill, 2130706432);
        encode("R5", 64'hFFFF_FFFF, 100, 0, 1'b0);
        chk("R5", "field cap unit 2 exponent", m_exp, 25);
        chk("R5", "field cap unit 2 mantissa", m_mant, 127);
        chk("R5", "field cap unit 2 fill", m_fill, 2130706432);
    endtask

    task automatic t_upper_mant;
        int n;
        @(negedge clk);
        s_start = 1'b1; s_burst = 32'd50000; s_rmant = 11'd10;
        @(posedge clk);
        @(negedge clk);
        s_start = 1'b0;
        n = 0;
        while (!s_done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R5", "mantissa cap exponent", s_exp, 7);
        chk("R5", "mantissa cap mantissa", s_mant, 127);
        chk("R5", "mantissa cap fill", s_fill, 16256);
        chk("R10", "mantissa cap latency", n, 10);
    endtask

    task automatic t_skip;
        encode("R9", 20000, 300, 2, 1'b1);
        chk("R9", "skip exponent", m_exp, 31);
        chk("R9", "skip mantissa", m_mant, 0);
        chk("R9", "skip fill", m_fill, 0);
    endtask

    task automatic t_ignore;
        int n;
        @(negedge clk);
        m_start = 1'b1; m_burst = 32'd20000; m_rmant = 11'd10; m_rexp = 4'd0; m_skip = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // second request while busy
        m_burst = 32'd50000; m_skip = 1'b1;
        repeat (3) @(negedge clk);
        m_start = 1'b0;
        wait_main_done(n);
        chk("R2", "ignored start mantissa", m_mant, 78);
        chk("R2", "ignored start exponent", m_exp, 8);
        chk("R2", "ignored start fill", m_fill, 19968);
        @(negedge clk);
        chk("R2", "idle after done", m_busy, 0);
    endtask

    task automatic t_hold;
        logic [MW-1:0] pm;
        logic [EW-1:0] pe;
        logic [BW-1:0] pf;
        encode("R2", 30000, 10, 0, 1'b0);
        pm = m_mant; pe = m_exp; pf = m_fill;
        m_burst = 32'd123; m_rmant = 11'd999; m_skip = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2", "done stays low", m_done, 0);
        end
        chk("R2", "held mantissa", m_mant, pm);
        chk("R2", "held exponent", m_exp, pe);
        chk("R2", "held fill", m_fill, pf);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_default();
        t_floor();
        t_tiers();
        t_upper_field();
        t_upper_mant();
        t_skip();
        t_ignore();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule